// File: doc/BRIEF.md
# Three-Wire Control Port Slave

This block is the control-side slave of an audio codec. A host microcontroller drives three lines into it: a phase-select line, a bit clock and a data line. While the phase-select line is low the host sends an address byte. That byte names the device and the kind of transfer that follows. While the line is high the host sends data bytes, or reads a short value back.

All three lines are brought into the system clock domain through a synchronizer. The rising edges of the bus clock are found there, and the bits are packed into bytes. Each byte takes effect only once its eighth bit has arrived, so a byte that is cut short leaves no trace.

For this device, a data phase can do one of three things:
- fill a small bank of direct control registers, one byte after another;
- update a 13-bit status word, which also sets the two converter power enables;
- return a 6-bit peak value on the data line, with an output enable for the pad.

Top module: `tw_ctl_slave`

## Requirements
- R1: Bits are taken on rising edges of the bus clock, least-significant bit first, and a byte is acted on only after its eighth bit; a phase-select change before that discards the partial byte.
- R2: A byte received with the phase-select line low is an address byte: bits [7:2] are the device address (default 6'h05) and bits [1:0] the transfer type: 00 direct write, 01 peak read-out, 10 status write, 11 none.
- R3: A non-matching device address, or type 11, makes every following data byte have no effect on direct_o, status_o or the data line until the next address byte.
- R4: In a direct write, successive data bytes go to register 0, 1, 2, … (byte i at direct_o[8i+7:8i]); each address byte restarts at register 0; bytes past the last register are dropped.
- R5: In a status write, a data byte with bit 7 = 0 sets status_o[0] = bit 6 (reset), [2:1] = bits 5:4 (clock select), [5:3] = bits 3:1 (input format) and [6] = bit 0 (DC filter). A byte with bit 7 = 1 sets [7] = bit 6 (input gain), [8] = bit 5 (output gain), [9] = bit 4 (polarity), [10] = bit 3 (double speed) and [12:11] = bits 1:0 (power).
- R6: The power field status_o[12:11] = {p1,p0} gives adc_en_o = p1 and dac_en_o = p0; 00 switches both converters off.
- R7: During a matched read-out data phase, ctl_dat_oe is 1. ctl_dat_o carries bit k of the peak value while k bus-clock edges of the current byte have passed; bits 6 and 7 are 0, and the value is sampled at phase entry and again after every eighth edge. At all other times ctl_dat_oe is 0.
- R8: A bus-clock rising edge seen in the same cycle as a phase-select change is counted as bit 0 of the new phase.
- R9: Reset clears direct_o to zero, sets status_o to 13'h1800 (both converters on), and drives ctl_dat_oe and ctl_dat_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_mode_i | input | 1 | Phase select: 0 address, 1 data |
| ctl_clk_i | input | 1 | Bus bit clock from the host |
| ctl_dat_i | input | 1 | Bus data from the host |
| peak_i | input | PEAK_W | Peak level to be read out |
| ctl_dat_o | output | 1 | Read-out data bit |
| ctl_dat_oe | output | 1 | Output enable for the data pad |
| direct_o | output | NUM_DIRECT*8 | Direct control register bank, register 0 in the low byte |
| status_o | output | 13 | Status word (layout in R5) |
| adc_en_o | output | 1 | ADC enable |
| dac_en_o | output | 1 | DAC enable |

## Verification
A phase change and a bus-clock edge can land in the same system cycle. In that cycle the bit counter must both clear and count. The bench provokes this by leaving three stray bits at the end of a data phase. It then lowers phase-select in the same instant that it raises the bus clock for the first address bit. It judges the result by sending a direct write after that address byte and checking register 0. The byte reaches register 0 only if that edge was counted as bit 0 of the address.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic [1:0] {
      XF_DIRECT = 2'b00,
      XF_READ   = 2'b01,
      XF_STATUS = 2'b10,
      XF_NONE   = 2'b11
   } xfer_t;

   localparam int unsigned STATUS_W = 13;
   localparam logic [STATUS_W-1:0] STATUS_RST = 13'h1800;

   // status word field positions
   localparam int unsigned ST_RST   = 0;
   localparam int unsigned ST_CLK   = 1;
   localparam int unsigned ST_FMT   = 3;
   localparam int unsigned ST_DCF   = 6;
   localparam int unsigned ST_IGN   = 7;
   localparam int unsigned ST_OGN   = 8;
   localparam int unsigned ST_POL   = 9;
   localparam int unsigned ST_DSP   = 10;
   localparam int unsigned ST_PWR   = 11;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tw_framer.sv
module tw_framer (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_s,
   input  logic       bclk_s,
   input  logic       dat_s,
   output logic       rise_o,
   output logic       phase_chg_o,
   output logic [2:0] bit_cnt_o,
   output logic [7:0] byte_o,
   output logic       byte_stb_o,
   output logic       byte_data_o
);
   logic       bclk_d;
   logic       mode_d;
   logic [7:0] shreg;
   logic [2:0] cnt;

   assign rise_o      = bclk_s & ~bclk_d;
   assign phase_chg_o = mode_s ^ mode_d;
   assign bit_cnt_o   = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_d      <= 1'b0;
         mode_d      <= 1'b0;
         shreg       <= '0;
         cnt         <= '0;
         byte_o      <= '0;
         byte_stb_o  <= 1'b0;
         byte_data_o <= 1'b0;
      end else begin
         bclk_d     <= bclk_s;
         mode_d     <= mode_s;
         byte_stb_o <= 1'b0;
         if (phase_chg_o) begin
            // partial byte dropped; a coincident edge starts the new phase
            if (rise_o) begin
               shreg <= {dat_s, 7'b0};
               cnt   <= 3'd1;
            end else begin
               cnt   <= 3'd0;
            end
         end else if (rise_o) begin
            shreg <= {dat_s, shreg[7:1]};
            if (cnt == 3'd7) begin
               byte_o      <= {dat_s, shreg[7:1]};
               byte_stb_o  <= 1'b1;
               byte_data_o <= mode_s;
               cnt         <= 3'd0;
            end else begin
               cnt <= cnt + 3'd1;
            end
         end
      end
   end
endmodule

// File: rtl/tw_regbank.sv
module tw_regbank
   import tw_pkg::*;
#(
   parameter int unsigned        NUM_DIRECT = 4,
   parameter logic [5:0]         DEV_ADDR   = 6'h05
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      byte_stb_i,
   input  logic                      byte_data_i,
   input  logic [7:0]                byte_i,
   output logic                      sel_read_o,
   output logic [NUM_DIRECT*8-1:0]   direct_o,
   output logic [STATUS_W-1:0]       status_o
);
   localparam int unsigned PW = $clog2(NUM_DIRECT + 1);
   localparam logic [PW-1:0] PTR_END = PW'(NUM_DIRECT);

   logic          addr_ok;
   xfer_t         xfer;
   logic [PW-1:0] ptr;
   logic          wr_direct;
   logic          wr_status;

   assign wr_direct  = byte_stb_i & byte_data_i & addr_ok & (xfer == XF_DIRECT);
   assign wr_status  = byte_stb_i & byte_data_i & addr_ok & (xfer == XF_STATUS);
   assign sel_read_o = addr_ok & (xfer == XF_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_ok <= 1'b0;
         xfer    <= XF_NONE;
         ptr     <= '0;
      end else if (byte_stb_i) begin
         if (!byte_data_i) begin
            addr_ok <= (byte_i[7:2] == DEV_ADDR);
            xfer    <= xfer_t'(byte_i[1:0]);
            ptr     <= '0;
         end else if (wr_direct && ptr != PTR_END) begin
            ptr <= ptr + PW'(1);
         end
      end
   end

   generate
      for (genvar g = 0; g < NUM_DIRECT; g++) begin : g_dreg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               direct_o[g*8 +: 8] <= '0;
            else if (wr_direct && ptr == PW'(g))
               direct_o[g*8 +: 8] <= byte_i;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_o <= STATUS_RST;
      end else if (wr_status) begin
         if (!byte_i[7]) begin
            status_o[ST_RST]        <= byte_i[6];
            status_o[ST_CLK +: 2]   <= byte_i[5:4];
            status_o[ST_FMT +: 3]   <= byte_i[3:1];
            status_o[ST_DCF]        <= byte_i[0];
         end else begin
            status_o[ST_IGN]        <= byte_i[6];
            status_o[ST_OGN]        <= byte_i[5];
            status_o[ST_POL]        <= byte_i[4];
            status_o[ST_DSP]        <= byte_i[3];
            status_o[ST_PWR +: 2]   <= byte_i[1:0];
         end
      end
   end
endmodule

// File: rtl/tw_readout.sv
module tw_readout #(
   parameter int unsigned PEAK_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_s,
   input  logic              phase_chg_i,
   input  logic              byte_stb_i,
   input  logic              sel_read_i,
   input  logic [2:0]        bit_cnt_i,
   input  logic [PEAK_W-1:0] peak_i,
   output logic              dat_o,
   output logic              dat_oe
);
   logic [7:0] snap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         snap <= '0;
      else if ((phase_chg_i && mode_s) || byte_stb_i)
         snap <= 8'(peak_i);
   end

   assign dat_oe = mode_s & sel_read_i;
   assign dat_o  = dat_oe & snap[bit_cnt_i];
endmodule

// File: rtl/tw_ctl_slave.sv
module tw_ctl_slave
   import tw_pkg::*;
#(
   parameter int unsigned NUM_DIRECT  = 4,
   parameter int unsigned PEAK_W      = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [5:0]  DEV_ADDR    = 6'h05
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ctl_mode_i,
   input  logic                    ctl_clk_i,
   input  logic                    ctl_dat_i,
   input  logic [PEAK_W-1:0]       peak_i,
   output logic                    ctl_dat_o,
   output logic                    ctl_dat_oe,
   output logic [NUM_DIRECT*8-1:0] direct_o,
   output logic [12:0]             status_o,
   output logic                    adc_en_o,
   output logic                    dac_en_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (PEAK_W < 1 || PEAK_W > 8) begin : g_bad_peak
         $error("PEAK_W must be 1..8");
      end
      if (NUM_DIRECT < 1 || NUM_DIRECT > 64) begin : g_bad_num
         $error("NUM_DIRECT must be 1..64");
      end
   endgenerate

   logic [2:0] sync_q;
   logic       mode_s, bclk_s, dat_s;
   logic       rise, phase_chg, byte_stb, byte_data, sel_read;
   logic [2:0] bit_cnt;
   logic [7:0] byte_q;

   tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ctl_mode_i, ctl_clk_i, ctl_dat_i}),
      .q_o   (sync_q)
   );
   assign {mode_s, bclk_s, dat_s} = sync_q;

   tw_framer u_framer (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_s      (mode_s),
      .bclk_s      (bclk_s),
      .dat_s       (dat_s),
      .rise_o      (rise),
      .phase_chg_o (phase_chg),
      .bit_cnt_o   (bit_cnt),
      .byte_o      (byte_q),
      .byte_stb_o  (byte_stb),
      .byte_data_o (byte_data)
   );

   tw_regbank #(.NUM_DIRECT(NUM_DIRECT), .DEV_ADDR(DEV_ADDR)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_stb_i  (byte_stb),
      .byte_data_i (byte_data),
      .byte_i      (byte_q),
      .sel_read_o  (sel_read),
      .direct_o    (direct_o),
      .status_o    (status_o)
   );

   tw_readout #(.PEAK_W(PEAK_W)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_s      (mode_s),
      .phase_chg_i (phase_chg),
      .byte_stb_i  (byte_stb),
      .sel_read_i  (sel_read),
      .bit_cnt_i   (bit_cnt),
      .peak_i      (peak_i),
      .dat_o       (ctl_dat_o),
      .dat_oe      (ctl_dat_oe)
   );

   assign adc_en_o = status_o[ST_PWR + 1];
   assign dac_en_o = status_o[ST_PWR];
endmodule

// File: rtl/tw_ctl_slave_chk.sv
module tw_ctl_slave_chk #(
   parameter int unsigned NUM_DIRECT = 4,
   parameter int unsigned PEAK_W     = 6
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    rise,
   input logic                    phase_chg,
   input logic                    byte_stb,
   input logic [2:0]              bit_cnt,
   input logic                    ctl_dat_o,
   input logic                    ctl_dat_oe,
   input logic [NUM_DIRECT*8-1:0] direct_o,
   input logic [12:0]             status_o,
   input logic                    adc_en_o,
   input logic                    dac_en_o
);
   // R1
   byte_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_stb |-> bit_cnt == 3'd0);

   // R1
   commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_stb |=> ($stable(status_o) && $stable(direct_o)));

   // R8
   phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_chg && !rise) |=> bit_cnt == 3'd0);

   // R8
   phase_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_chg && rise) |=> bit_cnt == 3'd1);

   // R6
   power_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[12:11] == 2'b00) |-> (!adc_en_o && !dac_en_o));

   // R7
   pad_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_dat_oe && 32'(bit_cnt) >= PEAK_W) |-> !ctl_dat_o);
endmodule

bind tw_ctl_slave tw_ctl_slave_chk #(.NUM_DIRECT(NUM_DIRECT), .PEAK_W(PEAK_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rise       (rise),
   .phase_chg  (phase_chg),
   .byte_stb   (byte_stb),
   .bit_cnt    (bit_cnt),
   .ctl_dat_o  (ctl_dat_o),
   .ctl_dat_oe (ctl_dat_oe),
   .direct_o   (direct_o),
   .status_o   (status_o),
   .adc_en_o   (adc_en_o),
   .dac_en_o   (dac_en_o)
);

// File: tb/tb_tw_ctl_slave.sv
module tb_tw_ctl_slave;
   localparam int NUM_DIRECT = 4;
   localparam int PEAK_W     = 6;
   localparam logic [5:0] DEV = 6'h05;
   localparam int H = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_i = 1'b0, c_i = 1'b0, d_i = 1'b0;
   logic [PEAK_W-1:0] peak = '0;
   logic dat_o, dat_oe, adc_en, dac_en;
   logic [NUM_DIRECT*8-1:0] direct;
   logic [12:0] status;

   int total = 0;
   int bad   = 0;
   logic [31:0] exp_dir;
   logic [12:0] exp_st;

   always #2 clk = ~clk;

   tw_ctl_slave #(.NUM_DIRECT(NUM_DIRECT), .PEAK_W(PEAK_W), .DEV_ADDR(DEV)) dut (
      .clk(clk), .rst_n(rst_n), .ctl_mode_i(m_i), .ctl_clk_i(c_i), .ctl_dat_i(d_i),
      .peak_i(peak), .ctl_dat_o(dat_o), .ctl_dat_oe(dat_oe), .direct_o(direct),
      .status_o(status), .adc_en_o(adc_en), .dac_en_o(dac_en)
   );

   // {type, dev, data}
   localparam logic [15:0] VEC [8] = '{
      {2'b00, 6'h05, 8'hA5},
      {2'b10, 6'h05, 8'h2B},
      {2'b10, 6'h05, 8'hDC},
      {2'b00, 6'h06, 8'hFF},
      {2'b11, 6'h05, 8'h77},
      {2'b00, 6'h05, 8'h3C},
      {2'b10, 6'h05, 8'h80},
      {2'b10, 6'h05, 8'h81}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send_bit(input logic b);
      d_i = b; wclk(H);
      c_i = 1'b1; wclk(H);
      c_i = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) send_bit(v[i]);
   endtask

   task automatic set_mode(input logic m);
      wclk(H); m_i = m; wclk(H);
   endtask

   function automatic logic [12:0] st_model(input logic [12:0] s, input logic [7:0] d);
      logic [12:0] r = s;
      if (!d[7]) begin
         r[0] = d[6]; r[2:1] = d[5:4]; r[5:3] = d[3:1]; r[6] = d[0];
      end else begin
         r[7] = d[6]; r[8] = d[5]; r[9] = d[4]; r[10] = d[3]; r[12:11] = d[1:0];
      end
      return r;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [5:0] pk;
      wclk(4);
      // R9 reset values
      chk("R9 direct", direct, 32'h0);
      chk("R9 status", {19'h0, status}, 32'h1800);
      chk("R9 oe", {31'h0, dat_oe}, 32'h0);
      rst_n = 1'b1; wclk(4);
      exp_dir = '0; exp_st = 13'h1800;

      // vector table: R2 R3 R5 R6
      for (int v = 0; v < 8; v++) begin
         logic [1:0] ty = VEC[v][15:14];
         logic [5:0] dv = VEC[v][13:8];
         logic [7:0] db = VEC[v][7:0];
         set_mode(0); send_byte({dv, ty});
         set_mode(1); send_byte(db);
         set_mode(0); wclk(10);
         if (dv == DEV && ty == 2'b00) exp_dir[7:0] = db;
         if (dv == DEV && ty == 2'b10) exp_st = st_model(exp_st, db);
         chk("R2/R3/R4 direct", direct, exp_dir);
         chk("R5 status", {19'h0, status}, {19'h0, exp_st});
         chk("R6 enables", {30'h0, adc_en, dac_en}, {30'h0, exp_st[12:11]});
      end

      // R4 multibyte with overflow byte dropped
      set_mode(0); send_byte({DEV, 2'b00});
      set_mode(1);
      send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44); send_byte(8'h55);
      set_mode(0); wclk(10);
      exp_dir = 32'h44332211;
      chk("R4 multibyte", direct, exp_dir);

      // R4 restart at register 0
      send_byte({DEV, 2'b00}); set_mode(1); send_byte(8'h9E); set_mode(0); wclk(10);
      exp_dir[7:0] = 8'h9E;
      chk("R4 restart", direct, exp_dir);

      // R1 partial byte discarded
      set_mode(1);
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      set_mode(0); wclk(10);
      chk("R1 partial", direct, exp_dir);
      // counter was cleared: next full address + data still lands in reg 0
      send_byte({DEV, 2'b00}); set_mode(1); send_byte(8'h5A); set_mode(0); wclk(10);
      exp_dir[7:0] = 8'h5A;
      chk("R1 realign", direct, exp_dir);

      // R7 read-out
      pk = 6'b101101; peak = pk;
      send_byte({DEV, 2'b01});
      set_mode(1); wclk(4);
      chk("R7 oe on", {31'h0, dat_oe}, 32'h1);
      for (int i = 0; i < 8; i++) begin
         chk("R7 bit", {31'h0, dat_o}, {31'h0, (i < 6) ? pk[i] : 1'b0});
         send_bit(1'b0); wclk(4);
      end
      set_mode(0); wclk(4);
      chk("R7 oe off", {31'h0, dat_oe}, 32'h0);

      // R3 read with wrong device
      send_byte({6'h2A, 2'b01}); set_mode(1); wclk(4);
      chk("R3 read ignored", {30'h0, dat_oe, dat_o}, 32'h0);
      set_mode(0);

      // R8 coincident phase change and bus-clock edge
      send_byte({DEV, 2'b00}); set_mode(1); send_byte(8'h01);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      wclk(H);
      begin
         logic [7:0] ab = {DEV, 2'b00};
         d_i = ab[0]; m_i = 1'b0; c_i = 1'b1; wclk(H); c_i = 1'b0;
         for (int i = 1; i < 8; i++) send_bit(ab[i]);
      end
      set_mode(1); send_byte(8'h96); set_mode(0); wclk(10);
      exp_dir[7:0] = 8'h96;
      chk("R8 coincident edge", direct, exp_dir);

      // R9 reset mid-run
      rst_n = 1'b0; wclk(2);
      chk("R9 re-reset direct", direct, 32'h0);
      chk("R9 re-reset status", {19'h0, status}, 32'h1800);
      rst_n = 1'b1; wclk(2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule